// File: doc/BRIEF.md
# Super I/O Indexed Configuration Port

This block holds a bank of 256 byte-wide configuration registers behind a two-byte I/O window. The window lives at base 0x3F0: offset 0 is an index port and offset 1 is a data port. Software first writes a register number to the index port. It then reads or writes that register through the data port. Reads of the index port return the current index.

An upstream bridge gates the window with a single enable bit (bit 1 of its configuration byte 0x85). When that bit is clear, the window does not respond. Reads return all ones and writes are discarded. The index survives disable and enable cycles.

Not every data write lands:
- Two read-only identification registers ignore data writes.
- The two serial-port base registers accept only one fixed legal value each.

A write that is filtered out leaves the register unchanged and reports no error. The upstream side is a plain synchronous strobe interface: a 1-bit offset and byte-wide data. Read data is registered, so it appears one cycle after the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset these registers hold the listed values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other register holds 0x00. The index is 0x00 and rdata_o is 0x00.
- R2: With the window enabled, a write strobe at offset 0 loads wdata_i into the index. A read strobe at offset 0 returns the index.
- R3: With the window enabled, a write strobe at offset 1 stores wdata_i into the register selected by the index, unless R5, R6 or R7 drops it. A read strobe at offset 1 returns that register.
- R4: rdata_o updates on the clock edge that samples rd_i high, so data is valid one cycle after the strobe. Without a read strobe, rdata_o holds its last value.
- R5: A data write to register 0xE7 is dropped unless the value is 0xFE.
- R6: A data write to register 0xE8 is dropped unless the value is 0xBE.
- R7: Registers 0xE0 and 0xE1 are read-only. Data writes to them are dropped.
- R8: While win_en_i is low, every read returns 0xFF. Writes change neither the index nor any register.
- R9: The index keeps its value across a disable and re-enable of the window.
- R10: When a read and a data write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_en_i | input | 1 | Window decode enable from the bridge configuration bit |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| off_i | input | 1 | Window offset: 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench targets the value filters on the two serial base registers. It writes illegal and legal values, so a filter that is missing, inverted or keyed to the wrong register is caught: it either corrupts the stored base or refuses the legal value. Writes to the read-only identification registers catch a filter that forgets them and overwrites the ID. A disabled-window phase writes both ports and then re-enables. A design that decodes while disabled shows a moved index or a changed register, and one that clears the index on disable returns 0x00 instead of the old index. A same-cycle read and write on one register catches a read path that forwards the new data and so breaks the one-cycle timing.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t ID_IDX    = 8'hE0;
  localparam byte_t REV_IDX   = 8'hE1;
  localparam byte_t SER1_IDX  = 8'hE7;
  localparam byte_t SER2_IDX  = 8'hE8;
  localparam byte_t SER1_LGL  = 8'hFE;
  localparam byte_t SER2_LGL  = 8'hBE;
  localparam byte_t OPEN_BUS  = 8'hFF;

  function automatic byte_t reset_value(input byte_t idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_read_only(input byte_t idx);
    return (idx == ID_IDX) || (idx == REV_IDX);
  endfunction

endpackage

// File: rtl/sio_wr_filter.sv
module sio_wr_filter
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              req_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o
);

  byte_t idx_b, data_b;
  logic  ro, lock_bad;

  assign idx_b  = byte_t'(idx_i);
  assign data_b = byte_t'(data_i);

  always_comb begin
    ro       = is_read_only(idx_b);
    lock_bad = 1'b0;
    if (idx_b == SER1_IDX && data_b != SER1_LGL) lock_bad = 1'b1;
    if (idx_b == SER2_IDX && data_b != SER2_LGL) lock_bad = 1'b1;
    accept_o = req_i && !ro && !lock_bad;
  end

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST = DATA_W'(reset_value(8'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q_o[g] <= RST;
      else if (we_i && waddr_i == IDX_W'(g))        q_o[g] <= wdata_i;
    end
  end

endmodule

// File: rtl/sio_rd_port.sv
module sio_rd_port
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              en_i,
  input  logic              off_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] rf_i [DEPTH],
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rd_sel;

  always_comb begin
    if (!en_i)      rd_sel = DATA_W'(OPEN_BUS);
    else if (off_i) rd_sel = rf_i[idx_i];
    else            rd_sel = DATA_W'(idx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_sel;
  end

  // R8
  closed_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !en_i |=> rdata_o == DATA_W'(OPEN_BUS));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R2
  idx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && en_i && !off_i |=> rdata_o == DATA_W'($past(idx_i)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] rf_q [DEPTH];
  logic              idx_we, data_req, data_we;

  assign idx_we   = wr_i && win_en_i && !off_i;
  assign data_req = wr_i && win_en_i &&  off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_we) idx_q <= IDX_W'(wdata_i);
  end

  sio_wr_filter #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_filter (
    .req_i    (data_req),
    .idx_i    (idx_q),
    .data_i   (wdata_i),
    .accept_o (data_we)
  );

  sio_reg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we),
    .waddr_i (idx_q),
    .wdata_i (wdata_i),
    .q_o     (rf_q)
  );

  sio_rd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .en_i    (win_en_i),
    .off_i   (off_i),
    .idx_i   (idx_q),
    .rf_i    (rf_q),
    .rdata_o (rdata_o)
  );

  // R8, R9
  idx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && win_en_i && !off_i) |=> $stable(idx_q));

  // R5
  ser1_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && off_i && idx_q == IDX_W'(SER1_IDX) && wdata_i != DATA_W'(SER1_LGL)
    |=> $stable(rf_q[SER1_IDX]));

  // R6
  ser2_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && off_i && idx_q == IDX_W'(SER2_IDX) && wdata_i != DATA_W'(SER2_LGL)
    |=> $stable(rf_q[SER2_IDX]));

  // R7
  id_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rf_q[ID_IDX]) && $stable(rf_q[REV_IDX]));

  // R8
  closed_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !win_en_i && idx_q == '0 |=> $stable(rf_q[0]));

  // R3
  store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && win_en_i && off_i && idx_q == IDX_W'(8'h10)
    |=> rf_q[8'h10] == $past(wdata_i));

endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_en = 1'b0, wr = 1'b0, rd = 1'b0, off = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  logic [7:0] exp_q [$];
  string      req_q [$];
  logic [7:0] last_rd;

  always #2 clk = ~clk;

  sio_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .win_en_i(win_en), .wr_i(wr), .rd_i(rd),
    .off_i(off), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // monitor: pop one expected item per read strobe
  always @(posedge clk) begin
    if (rd && rst_n) begin
      #1;
      if (exp_q.size() == 0) check(rdata, 8'hxx, "scoreboard underflow");
      else check(rdata, exp_q.pop_front(), req_q.pop_front());
      last_rd = rdata;
    end
  end

  task automatic wr_byte(input logic o, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; off = o; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_byte(input logic o, input logic [7:0] e, input string req);
    @(negedge clk); rd = 1'b1; off = o; exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] e, input string req);
    wr_byte(1'b0, idx);
    rd_byte(1'b1, e, req);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #10; rst_n = 1'b1;
    @(negedge clk);
    check(rdata, 8'h00, "R1 rdata reset");
    // R8: closed window reads open bus
    rd_byte(1'b0, 8'hFF, "R8 closed idx read");
    rd_byte(1'b1, 8'hFF, "R8 closed data read");
    win_en = 1'b1;
    rd_byte(1'b0, 8'h00, "R1 index reset");
    rd_byte(1'b1, 8'h00, "R1 reg00 reset");
    rd_reg(8'hE0, 8'h3C, "R1 E0");
    rd_reg(8'hE2, 8'h03, "R1 E2");
    rd_reg(8'hE3, 8'hFC, "R1 E3");
    rd_reg(8'hE6, 8'hDE, "R1 E6");
    rd_reg(8'hE7, 8'hFE, "R1 E7");
    rd_reg(8'hE8, 8'hBE, "R1 E8");
    rd_reg(8'h55, 8'h00, "R1 other");
    // R2 / R3
    wr_byte(1'b0, 8'h10);
    rd_byte(1'b0, 8'h10, "R2 idx readback");
    wr_byte(1'b1, 8'hA5);
    rd_byte(1'b1, 8'hA5, "R3 data store");
    wr_byte(1'b0, 8'h7F); wr_byte(1'b1, 8'h3C);
    rd_byte(1'b1, 8'h3C, "R3 second reg");
    rd_reg(8'h10, 8'hA5, "R3 no alias");
    // R4: hold without strobe
    repeat (3) @(negedge clk);
    check(rdata, 8'hA5, "R4 hold");
    // R5
    wr_byte(1'b0, 8'hE7); wr_byte(1'b1, 8'h12);
    rd_byte(1'b1, 8'hFE, "R5 illegal dropped");
    wr_byte(1'b1, 8'hFE);
    rd_byte(1'b1, 8'hFE, "R5 legal");
    // R6
    wr_byte(1'b0, 8'hE8); wr_byte(1'b1, 8'hFE);
    rd_byte(1'b1, 8'hBE, "R6 illegal dropped");
    wr_byte(1'b1, 8'hBE);
    rd_byte(1'b1, 8'hBE, "R6 legal");
    // R7
    wr_byte(1'b0, 8'hE0); wr_byte(1'b1, 8'h00);
    rd_byte(1'b1, 8'h3C, "R7 E0 ro");
    wr_byte(1'b0, 8'hE1); wr_byte(1'b1, 8'h77);
    rd_byte(1'b1, 8'h00, "R7 E1 ro");
    // R8 / R9
    wr_byte(1'b0, 8'h20); wr_byte(1'b1, 8'h44);
    win_en = 1'b0;
    wr_byte(1'b0, 8'h30);
    wr_byte(1'b1, 8'h99);
    rd_byte(1'b0, 8'hFF, "R8 closed idx");
    win_en = 1'b1;
    rd_byte(1'b0, 8'h20, "R9 idx kept");
    rd_byte(1'b1, 8'h44, "R8 write ignored");
    rd_reg(8'h30, 8'h00, "R8 other reg untouched");
    // R10
    wr_byte(1'b0, 8'h40); wr_byte(1'b1, 8'h11);
    @(negedge clk); rd = 1'b1; wr = 1'b1; off = 1'b1; wdata = 8'h22;
    exp_q.push_back(8'h11); req_q.push_back("R10 read old");
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    rd_byte(1'b1, 8'h22, "R10 write landed");
    repeat (3) @(negedge clk);
    check(8'(exp_q.size()), 8'h00, "scoreboard drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule